// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns a 32-bit linear address into a physical address. While paging is switched off, the address comes back unchanged one cycle after the block accepts it. While paging is on, the block first looks in a small fully associative translation cache. The cache is keyed on the upper twenty bits of the address, which are the directory index and the page index taken together. A hit returns the cached frame joined to the 12-bit offset, and it takes no memory traffic.

On a miss the block reads a directory entry and then a page table entry through a single memory read port. If either entry is marked absent, the block answers with a page fault. A successful walk fills one cache slot, and slots are chosen in rotation. A flush input empties the whole cache, as a process switch needs.

Requests are accepted one at a time. A new request may be presented in the same cycle as the previous response.

Top module: `pt_walker`

## Requirements
- R1: When paging is off at acceptance, the cycle after acceptance carries `rsp_valid` with `rsp_paddr` equal to the linear address and `rsp_fault` low. No memory read is made.
- R2: A translation that misses the cache first reads the directory entry at address {`pt_base`[31:12], linear[31:22], 2'b00}. Linear bits 31:22 are the directory index, 21:12 the page index and 11:0 the offset.
- R3: When the directory entry is present, the second read is at {entry[31:12], linear[21:12], 2'b00}. A present table entry gives `rsp_paddr` = {table entry[31:12], linear[11:0]} with no fault.
- R4: If bit 0 (present) of the directory entry is clear, the block answers with `rsp_fault` high and `rsp_paddr` zero after that single read, and makes no table read.
- R5: If bit 0 of the table entry is clear, the block answers with `rsp_fault` high and `rsp_paddr` zero after both reads.
- R6: On a cache hit with paging on, the response comes the cycle after acceptance with the cached frame and the request's offset, and no memory read is made.
- R7: The cache holds 8 translations with no duplicate tags. Successful walks fill slots in rotation starting at slot 0, so the ninth distinct page evicts the first. Faulting walks install nothing.
- R8: `tlb_flush` empties every slot and restarts the rotation at slot 0. A request accepted in a flush cycle is treated as a miss. A walk that is in progress when a flush arrives does not install its result.
- R9: `mem_rd_en` stays high with a stable `mem_rd_addr` until `mem_rd_valid`. `rsp_valid` is a one-cycle pulse. `req_ready` is high whenever no walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| paging_en | input | 1 | Paging enable, sampled at acceptance |
| pt_base | input | 32 | Directory base; bits 31:12 used, held stable during walks |
| tlb_flush | input | 1 | Invalidate every cache slot |
| mem_rd_en | output | 1 | Memory read request, held until answered |
| mem_rd_addr | output | 32 | Word address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid for the current request |
| mem_rd_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_fault | output | 1 | Page fault: an absent entry was met |

## Verification
On every cycle the assertions check five things:
- the one-cycle passthrough answer;
- the address of the directory read;
- the fault that follows an absent directory entry;
- the zero-read answer on a cache hit;
- the read-port hold rule.

They also check that a flush leaves no valid slot and that no two slots ever match one address. The rotation order, the exclusion of faulting and flushed walks from the cache, and the exact frame values can only be shown by the bench. It sweeps many directory and page combinations against an arithmetic page table model and then replays chosen sequences that fill, evict, flush and refill the cache.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int TLB_N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_laddr,
  output logic        req_ready,
  input  logic        paging_en,
  input  logic [31:0] pt_base,
  input  logic        tlb_flush,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault
);
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL} st_t;

  st_t         st;
  logic [31:0] la_q;
  logic [19:0] pt_q;
  logic        stale_q;
  logic [IW-1:0] rr_q;
  logic [TLB_N-1:0] tv_q;
  logic [19:0] tt_q [TLB_N];
  logic [19:0] tf_q [TLB_N];

  logic [TLB_N-1:0] hv;
  logic [19:0] hf;
  logic hit, accept, present, install;
  logic unused_bits;

  assign unused_bits = ^{mem_rd_data[11:1], pt_base[11:0]};

  for (genvar i = 0; i < TLB_N; i++) begin : g_match
    assign hv[i] = tv_q[i] && (tt_q[i] == req_laddr[31:12]);
  end

  always_comb begin
    hf = '0;
    for (int i = 0; i < TLB_N; i++)
      if (hv[i]) hf = hf | tf_q[i];
  end

  assign hit         = (|hv) && !tlb_flush;
  assign req_ready   = (st == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign present     = mem_rd_data[0];
  assign mem_rd_en   = (st != S_IDLE);
  assign mem_rd_addr = (st == S_DIR) ? {pt_base[31:12], la_q[31:22], 2'b00}
                                     : {pt_q, la_q[21:12], 2'b00};
  assign install     = (st == S_TBL) && mem_rd_valid && present && !stale_q && !tlb_flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      la_q      <= '0;
      pt_q      <= '0;
      stale_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          la_q    <= req_laddr;
          stale_q <= 1'b0;
          if (!paging_en) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= req_laddr;
            rsp_fault <= 1'b0;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= {hf, req_laddr[11:0]};
            rsp_fault <= 1'b0;
          end else begin
            st <= S_DIR;
          end
        end
        S_DIR: if (mem_rd_valid) begin
          if (present) begin
            pt_q <= mem_rd_data[31:12];
            st   <= S_TBL;
          end else begin
            rsp_valid <= 1'b1;
            rsp_paddr <= '0;
            rsp_fault <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_TBL: if (mem_rd_valid) begin
          rsp_valid <= 1'b1;
          rsp_paddr <= present ? {mem_rd_data[31:12], la_q[11:0]} : 32'd0;
          rsp_fault <= !present;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (tlb_flush && st != S_IDLE) stale_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tlb_flush) begin
      tv_q <= '0;
      rr_q <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        tt_q[i] <= '0;
        tf_q[i] <= '0;
      end
    end else if (install) begin
      tv_q[rr_q] <= 1'b1;
      tt_q[rr_q] <= la_q[31:12];
      tf_q[rr_q] <= mem_rd_data[31:12];
      rr_q       <= (rr_q == IW'(TLB_N - 1)) ? '0 : rr_q + IW'(1);
    end
  end

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !paging_en) |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_laddr)));

  p_dir_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && paging_en && !hit) |=>
      (mem_rd_en && mem_rd_addr == {$past(pt_base[31:12]), $past(req_laddr[31:22]), 2'b00}));

  p_dir_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIR && mem_rd_valid && !mem_rd_data[0]) |=> (rsp_valid && rsp_fault && !mem_rd_en));

  p_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && paging_en && hit) |=> (rsp_valid && !rsp_fault && !mem_rd_en));

  p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |=> (tv_q == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam logic [19:0] BASE_PN = 20'h00100;
  localparam logic [19:0] TBL_PN  = 20'h00200;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, paging_en = 0, tlb_flush = 0;
  logic [31:0] req_laddr = '0;
  logic [31:0] pt_base = {BASE_PN, 12'h0};
  logic req_ready, mem_rd_en, mem_rd_valid, rsp_valid, rsp_fault;
  logic [31:0] mem_rd_addr, mem_rd_data, rsp_paddr;

  int errors = 0, checks = 0;
  int lat = 0, cnt = 0, nrd = 0;
  logic [31:0] rda [4];
  logic prev_hold = 0;
  logic [31:0] prev_addr = '0;

  always #4 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_ready(req_ready), .paging_en(paging_en), .pt_base(pt_base),
    .tlb_flush(tlb_flush), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  function automatic bit dir_ok(logic [9:0] d); return (d % 5) != 3; endfunction
  function automatic bit pg_ok(logic [9:0] p);  return (p % 7) != 6; endfunction
  function automatic logic [19:0] frame(logic [9:0] d, logic [9:0] p);
    return {d, p} ^ 20'hA5A5A;
  endfunction

  function automatic logic [31:0] mem_val(logic [31:0] a);
    logic [19:0] t;
    if (a[31:12] == BASE_PN)
      return {TBL_PN + 20'(a[11:2]), 11'h0, dir_ok(a[11:2])};
    t = a[31:12] - TBL_PN;
    return {frame(t[9:0], a[11:2]), 11'h0, pg_ok(a[11:2])};
  endfunction

  assign mem_rd_valid = mem_rd_en && (cnt >= lat);
  assign mem_rd_data  = mem_rd_valid ? mem_val(mem_rd_addr) : 32'hDEAD_BEEE;

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (mem_rd_en && !mem_rd_valid) cnt <= cnt + 1;
    else cnt <= 0;
    if (rst_n && mem_rd_en && mem_rd_valid) begin
      if (nrd < 4) rda[nrd] = mem_rd_addr;
      nrd = nrd + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9 read-port hold rule, sampled between edges
  always @(negedge clk) begin
    if (rst_n && prev_hold)
      chk(mem_rd_en && mem_rd_addr == prev_addr, "R9 read hold", mem_rd_addr, prev_addr);
    prev_hold = rst_n && mem_rd_en && !mem_rd_valid;
    prev_addr = mem_rd_addr;
  end

  task automatic xlate(input logic [31:0] la, input bit pg, input bit fl,
                       output logic [31:0] pa, output bit f, output int cyc);
    while (!req_ready) @(negedge clk);
    nrd = 0;
    req_valid = 1; req_laddr = la; paging_en = pg; tlb_flush = fl;
    @(negedge clk);
    req_valid = 0; tlb_flush = 0;
    cyc = 1;
    while (!rsp_valid && cyc < 500) begin @(negedge clk); cyc++; end
    pa = rsp_paddr; f = rsp_fault;
    chk(rsp_valid, "R9 response arrives", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 one-cycle pulse, ready", {rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic run(input logic [31:0] la, input bit want_hit, input bit fl = 0);
    logic [9:0] d, p;
    logic [31:0] pa, ea;
    bit f, ef;
    int cyc, er;
    d = la[31:22]; p = la[21:12];
    ef = !dir_ok(d) || !pg_ok(p);
    ea = ef ? 32'd0 : {frame(d, p), la[11:0]};
    er = !dir_ok(d) ? 1 : 2;
    xlate(la, 1'b1, fl, pa, f, cyc);
    chk(pa == ea && f == ef, want_hit ? "R6 hit result" : "R3 walk result", pa, ea);
    if (want_hit) begin
      chk(cyc == 1, "R6 hit latency", 32'(cyc), 32'd1);
      chk(nrd == 0, "R6 no reads on hit", 32'(nrd), 32'd0);
    end else begin
      chk(nrd == er, !dir_ok(d) ? "R4 single read" : (ef ? "R5 two reads" : "R7 miss reads"), 32'(nrd), 32'(er));
      chk(rda[0] == {BASE_PN, d, 2'b00}, "R2 directory address", rda[0], {BASE_PN, d, 2'b00});
      if (dir_ok(d))
        chk(rda[1] == {TBL_PN + 20'(d), p, 2'b00}, "R3 table address", rda[1], {TBL_PN + 20'(d), p, 2'b00});
    end
  endtask

  function automatic logic [31:0] mk(int d, int p);
    return {10'(d), 10'(p), 12'((d * 37 + p * 11 + 5) & 12'hFFF)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    bit f;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en, "R9 reset state",
        {rsp_valid, mem_rd_en, req_ready}, 32'd1);

    // R1 passthrough
    foreach (rda[i]) rda[i] = '0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : (i == 2) ? 32'h1234_5678 : mk(2, 3);
      xlate(a, 1'b0, 1'b0, pa, f, cyc);
      chk(pa == a && !f, "R1 passthrough value", pa, a);
      chk(cyc == 1 && nrd == 0, "R1 latency and no reads", 32'(cyc * 16 + nrd), 32'd16);
    end

    // Sweep of walks R2 R3 R4 R5
    for (int d = 0; d < 64; d++) begin
      for (int k = 0; k < 5; k++) begin
        int p;
        p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 6 : (k == 3) ? 13 : 1023;
        lat = (d + k) % 3;
        run(mk(d, p), 1'b0);
      end
    end

    // R6 repeat of a just-walked page with a new offset
    lat = 1;
    run(mk(1, 1), 1'b0);
    run({mk(1, 1)[31:12], 12'hABC}, 1'b1);
    xlate(mk(1, 1), 1'b0, 1'b0, pa, f, cyc);
    chk(pa == mk(1, 1), "R1 passthrough ignores cache", pa, mk(1, 1));

    // R7 rotation and eviction
    run(mk(1, 0), 1'b0, 1'b1);
    for (int i = 1; i < 8; i++) run(mk(1, (i < 6) ? i : i + 1), 1'b0);
    for (int i = 0; i < 8; i++) run(mk(1, (i < 6) ? i : i + 1), 1'b1);
    run(mk(1, 9), 1'b0);
    for (int i = 1; i < 8; i++) run(mk(1, (i < 6) ? i : i + 1), 1'b1);
    run(mk(1, 0), 1'b0);
    run(mk(1, 1), 1'b0);
    run(mk(1, 3), 1'b1);
    run(mk(1, 9), 1'b1);

    // R7 faults not cached
    run(mk(3, 4), 1'b0);
    run(mk(3, 4), 1'b0);
    run(mk(1, 6), 1'b0);
    run(mk(1, 6), 1'b0);

    // R8 flush empties the cache
    run(mk(1, 3), 1'b1);
    @(negedge clk); tlb_flush = 1; @(negedge clk); tlb_flush = 0;
    run(mk(1, 3), 1'b0);
    run(mk(1, 3), 1'b1);

    // R8 request in flush cycle is a miss
    run(mk(1, 3), 1'b0, 1'b1);
    run(mk(1, 3), 1'b1);

    // R8 flush during a walk blocks installation
    lat = 3;
    fork
      run(mk(7, 2), 1'b0);
      begin
        @(negedge clk); @(negedge clk);
        tlb_flush = 1;
        @(negedge clk);
        tlb_flush = 0;
      end
    join
    run(mk(7, 2), 1'b0);
    run(mk(7, 2), 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule